// File: doc/BRIEF.md
# Raster Timing Generator

The block produces the timing skeleton of a progressive video raster. For each axis it is given four lengths: the sync pulse, the back porch, the visible area and the front porch. From these it derives, per axis, the last count of the line or frame, the count where sync ends, the count where blanking ends and the count where blanking begins again. A horizontal counter steps once per clock. A vertical counter steps once per completed line. Comparing both counters against the derived positions gives active-low sync outputs, a blank flag, an active-area flag and a one-cycle frame-start pulse.

All positions are zero-based. Sync occupies counts 0 through sync length minus one. The back porch follows, then the visible area, then the front porch.

The configuration inputs are not used directly. A rising edge on the update strobe captures all eight lengths into a shadow set. The shadow set is copied into the working set when the current frame ends, so a frame is never torn. After reset nothing runs. The first update starts the raster without waiting.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset and before any update, the outputs are idle: `hsync_no`=1, `vsync_no`=1, `blank_o`=1, `active_o`=0, `frame_start_o`=0, and both counts are 0.
- R2: While running, `h_count_o` runs 0..H_total-1 and then wraps to 0. `v_count_o` advances by one on each horizontal wrap and wraps to 0 after V_total-1. A frame therefore lasts H_total*V_total cycles, where total = sync + back porch + active + front porch.
- R3: `hsync_no` is 0 exactly while h is in 0..hsync_len-1. `vsync_no` is 0 exactly while v is in 0..vsync_len-1.
- R4: `active_o` is 1 exactly when h is in [hsync_len+hback, hsync_len+hback+hactive-1] and v is in the corresponding vertical range. This gives hactive pixels per line and vactive lines per frame.
- R5: While running, `blank_o` is the inverse of `active_o`, and every sync cycle is blanked.
- R6: `frame_start_o` is 1 for exactly the cycle in which both counts are 0.
- R7: Changes on the length inputs have no effect unless `update_i` rises. This holds both while idle and while running.
- R8: A rising edge of `update_i` in mid-frame captures the lengths. The running frame finishes with the old timing, and the new timing applies from the next position (0,0).
- R9: The first rising edge of `update_i` after reset is sampled at clock edge E1. The raster starts at the next edge E2: after E2 the counts are (0,0) and `frame_start_o` is 1. After E1 the outputs are still idle.

Each sync length must be at least 1. Each axis total must fit in `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Update strobe; its rising edge captures the lengths |
| h_sync_len_i | input | CNT_W | Horizontal sync length |
| h_back_porch_i | input | CNT_W | Horizontal back porch |
| h_active_i | input | CNT_W | Visible pixels per line |
| h_front_porch_i | input | CNT_W | Horizontal front porch |
| v_sync_len_i | input | CNT_W | Vertical sync length in lines |
| v_back_porch_i | input | CNT_W | Vertical back porch in lines |
| v_active_i | input | CNT_W | Visible lines per frame |
| v_front_porch_i | input | CNT_W | Vertical front porch in lines |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | Outside the active area |
| active_o | output | 1 | Inside the active area |
| frame_start_o | output | 1 | One-cycle pulse at position (0,0) |
| h_count_o | output | CNT_W | Horizontal position |
| v_count_o | output | CNT_W | Vertical position |

## Verification
The bench builds the block with `CNT_W`=6 and uses two raster shapes: 12x7 and 9x7. Each frame is under a hundred cycles, so every pixel position of every frame is compared against an arithmetic model. The checks cover the reset idle state, the start-up latency and the sync, back-porch, active and front-porch edges of both shapes. The small size also allows the bench to change the inputs without an update, and to issue an update in mid-frame, and still observe the complete old frame and the complete new frame that follows.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NUM_AXES = 2;
  localparam int AXIS_H   = 0;
  localparam int AXIS_V   = 1;

  typedef enum logic [1:0] {
    PH_SYNC,
    PH_BACK,
    PH_ACTIVE,
    PH_FRONT
  } phase_e;
endpackage

// File: rtl/rtg_cfg.sv
// Per-axis configuration: shadow set loaded on capture, working set loaded on apply.
module rtg_cfg #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] sync_len_i,
  input  logic [CNT_W-1:0] back_i,
  input  logic [CNT_W-1:0] active_i,
  input  logic [CNT_W-1:0] front_i,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] sync_end_o,
  output logic [CNT_W-1:0] blank_end_o,
  output logic [CNT_W-1:0] blank_start_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] d_last, d_sync_end, d_blank_end, d_blank_start;
  logic [CNT_W-1:0] sh_last, sh_sync_end, sh_blank_end, sh_blank_start;

  // Positions are derived cumulatively from the sync start at 0.
  always_comb begin
    d_sync_end    = sync_len_i - ONE;
    d_blank_end   = d_sync_end + back_i;
    d_blank_start = d_blank_end + active_i;
    d_last        = d_blank_start + front_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_last        <= '0;
      sh_sync_end    <= '0;
      sh_blank_end   <= '0;
      sh_blank_start <= '0;
    end else if (capture_i) begin
      sh_last        <= d_last;
      sh_sync_end    <= d_sync_end;
      sh_blank_end   <= d_blank_end;
      sh_blank_start <= d_blank_start;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o        <= '0;
      sync_end_o    <= '0;
      blank_end_o   <= '0;
      blank_start_o <= '0;
    end else if (apply_i) begin
      last_o        <= sh_last;
      sync_end_o    <= sh_sync_end;
      blank_end_o   <= sh_blank_end;
      blank_start_o <= sh_blank_start;
    end
  end

  AST_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_end_o >= sync_end_o) || (last_o == '0)) else $error("phase order");  // R5
endmodule

// File: rtl/rtg_axis.sv
// One axis position counter with phase decode.
module rtg_axis #(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [CNT_W-1:0]  last_i,
  input  logic [CNT_W-1:0]  sync_end_i,
  input  logic [CNT_W-1:0]  blank_end_i,
  input  logic [CNT_W-1:0]  blank_start_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output rtg_pkg::phase_e   phase_o
);
  import rtg_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_last;

  assign at_last = (cnt_o == last_i);
  assign wrap_o  = step_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (step_i)    cnt_o <= at_last ? '0 : cnt_o + ONE;
  end

  always_comb begin
    if (cnt_o <= sync_end_i)         phase_o = PH_SYNC;
    else if (cnt_o <= blank_end_i)   phase_o = PH_BACK;
    else if (cnt_o <= blank_start_i) phase_o = PH_ACTIVE;
    else                             phase_o = PH_FRONT;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && at_last) |=> (cnt_o == '0)) else $error("wrap");  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_o <= last_i)) else $error("overflow");  // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(cnt_o)) else $error("hold");  // R2
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             update_i,
  input  logic [CNT_W-1:0] h_sync_len_i,
  input  logic [CNT_W-1:0] h_back_porch_i,
  input  logic [CNT_W-1:0] h_active_i,
  input  logic [CNT_W-1:0] h_front_porch_i,
  input  logic [CNT_W-1:0] v_sync_len_i,
  input  logic [CNT_W-1:0] v_back_porch_i,
  input  logic [CNT_W-1:0] v_active_i,
  input  logic [CNT_W-1:0] v_front_porch_i,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             blank_o,
  output logic             active_o,
  output logic             frame_start_o,
  output logic [CNT_W-1:0] h_count_o,
  output logic [CNT_W-1:0] v_count_o
);
  import rtg_pkg::*;

  logic [NUM_AXES-1:0][CNT_W-1:0] cfg_sync, cfg_back, cfg_act, cfg_front;
  logic [NUM_AXES-1:0][CNT_W-1:0] ax_last, ax_sync_end, ax_blank_end, ax_blank_start;
  logic [NUM_AXES-1:0][CNT_W-1:0] ax_cnt;
  logic [NUM_AXES-1:0]            ax_step, ax_wrap;
  phase_e                         ax_phase [NUM_AXES];

  logic update_q, pending_q, run_q;
  logic capture, apply, frame_end;

  assign cfg_sync[AXIS_H]  = h_sync_len_i;
  assign cfg_back[AXIS_H]  = h_back_porch_i;
  assign cfg_act[AXIS_H]   = h_active_i;
  assign cfg_front[AXIS_H] = h_front_porch_i;
  assign cfg_sync[AXIS_V]  = v_sync_len_i;
  assign cfg_back[AXIS_V]  = v_back_porch_i;
  assign cfg_act[AXIS_V]   = v_active_i;
  assign cfg_front[AXIS_V] = v_front_porch_i;

  assign capture   = update_i && !update_q;
  assign frame_end = ax_wrap[AXIS_V];
  assign apply     = pending_q && (!run_q || frame_end);

  assign ax_step[AXIS_H] = run_q;
  assign ax_step[AXIS_V] = ax_wrap[AXIS_H];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      update_q  <= 1'b0;
      pending_q <= 1'b0;
      run_q     <= 1'b0;
    end else begin
      update_q <= update_i;
      if (capture)    pending_q <= 1'b1;
      else if (apply) pending_q <= 1'b0;
      if (apply)      run_q <= 1'b1;
    end
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    rtg_cfg #(.CNT_W(CNT_W)) cfg_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .capture_i    (capture),
      .apply_i      (apply),
      .sync_len_i   (cfg_sync[a]),
      .back_i       (cfg_back[a]),
      .active_i     (cfg_act[a]),
      .front_i      (cfg_front[a]),
      .last_o       (ax_last[a]),
      .sync_end_o   (ax_sync_end[a]),
      .blank_end_o  (ax_blank_end[a]),
      .blank_start_o(ax_blank_start[a])
    );

    rtg_axis #(.CNT_W(CNT_W)) cnt_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (run_q),
      .step_i       (ax_step[a]),
      .restart_i    (apply),
      .last_i       (ax_last[a]),
      .sync_end_i   (ax_sync_end[a]),
      .blank_end_i  (ax_blank_end[a]),
      .blank_start_i(ax_blank_start[a]),
      .cnt_o        (ax_cnt[a]),
      .wrap_o       (ax_wrap[a]),
      .phase_o      (ax_phase[a])
    );
  end

  assign h_count_o     = ax_cnt[AXIS_H];
  assign v_count_o     = ax_cnt[AXIS_V];
  assign hsync_no      = !(run_q && ax_phase[AXIS_H] == PH_SYNC);
  assign vsync_no      = !(run_q && ax_phase[AXIS_V] == PH_SYNC);
  assign active_o      = run_q && ax_phase[AXIS_H] == PH_ACTIVE && ax_phase[AXIS_V] == PH_ACTIVE;
  assign blank_o       = !active_o;
  assign frame_start_o = run_q && ax_cnt[AXIS_H] == '0 && ax_cnt[AXIS_V] == '0;

  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (hsync_no && vsync_no && blank_o && !frame_start_o)) else $error("idle");  // R1
  AST_SYNC_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_no || !vsync_no) |-> blank_o) else $error("sync in active");  // R5
  AST_FS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && ax_last[AXIS_H] != '0) |=> !frame_start_o) else $error("fs width");  // R6
  AST_CFG_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !frame_end) |=> ($stable(ax_last) && $stable(ax_blank_start))) else $error("torn frame");  // R8
  AST_START_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && !run_q) |=> ##1 frame_start_o) else $error("start");  // R9
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb_top;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [W-1:0] hs_i, hb_i, ha_i, hf_i, vs_i, vb_i, va_i, vf_i;
  logic hsync_n, vsync_n, blank, active, fs;
  logic [W-1:0] hcnt, vcnt;

  raster_timing_gen #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .update_i(upd),
    .h_sync_len_i(hs_i), .h_back_porch_i(hb_i), .h_active_i(ha_i), .h_front_porch_i(hf_i),
    .v_sync_len_i(vs_i), .v_back_porch_i(vb_i), .v_active_i(va_i), .v_front_porch_i(vf_i),
    .hsync_no(hsync_n), .vsync_no(vsync_n), .blank_o(blank), .active_o(active),
    .frame_start_o(fs), .h_count_o(hcnt), .v_count_o(vcnt)
  );

  always #2 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  int cfg_a [8] = '{2, 3, 5, 2, 1, 2, 3, 1};
  int cfg_b [8] = '{1, 1, 4, 3, 2, 1, 2, 2};
  int cur [8];
  int nxt [8];
  bit pend = 1'b0;
  int ex = 0, ey = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int c [8]);
    hs_i = W'(c[0]); hb_i = W'(c[1]); ha_i = W'(c[2]); hf_i = W'(c[3]);
    vs_i = W'(c[4]); vb_i = W'(c[5]); va_i = W'(c[6]); vf_i = W'(c[7]);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_idle(string tag);
    chk(hsync_n && vsync_n, {tag, " syncs idle high"}, int'({hsync_n, vsync_n}), 3);
    chk(blank && !active && !fs, {tag, " blank idle"}, int'({blank, active, fs}), 4);
    chk(hcnt == '0 && vcnt == '0, {tag, " counts zero"}, int'(hcnt) * 1000 + int'(vcnt), 0);
  endtask

  task automatic cmp();
    bit ah, av, act;
    ah  = ex >= cur[0] + cur[1] && ex < cur[0] + cur[1] + cur[2];
    av  = ey >= cur[4] + cur[5] && ey < cur[4] + cur[5] + cur[6];
    act = ah && av;
    chk(int'(hcnt) == ex && int'(vcnt) == ey, "R2 position",
        int'(hcnt) * 1000 + int'(vcnt), ex * 1000 + ey);
    chk(hsync_n == (ex >= cur[0]), "R3 hsync", int'(hsync_n), int'(ex >= cur[0]));
    chk(vsync_n == (ey >= cur[4]), "R3 vsync", int'(vsync_n), int'(ey >= cur[4]));
    chk(active == act, "R4 active", int'(active), int'(act));
    chk(blank == !act, "R5 blank", int'(blank), int'(!act));
    chk(fs == (ex == 0 && ey == 0), "R6 frame start", int'(fs), int'(ex == 0 && ey == 0));
  endtask

  task automatic advance();
    int ht, vt;
    ht = cur[0] + cur[1] + cur[2] + cur[3];
    vt = cur[4] + cur[5] + cur[6] + cur[7];
    if (ex == ht - 1) begin
      ex = 0;
      if (ey == vt - 1) begin
        ey = 0;
        if (pend) begin
          cur  = nxt;
          pend = 1'b0;
        end
      end else ey++;
    end else ex++;
  endtask

  // Runs one full frame of the current model shape; optional mid-frame update or input change.
  task automatic run_frame(string tag, int upd_at, int chg_at, int newc [8]);
    int c [8];
    int n, hs_low, vs_low, pix, lines;
    c = cur;
    n = (c[0] + c[1] + c[2] + c[3]) * (c[4] + c[5] + c[6] + c[7]);
    hs_low = 0; vs_low = 0; pix = 0; lines = 0;
    for (int i = 0; i < n; i++) begin
      cmp();
      if (int'(vcnt) == 0 && !hsync_n) hs_low++;
      if (int'(hcnt) == 0 && !vsync_n) vs_low++;
      if (active && int'(vcnt) == c[4] + c[5]) pix++;
      if (active && int'(hcnt) == c[0] + c[1]) lines++;
      if (i == upd_at + 1) upd = 1'b0;
      if (i == upd_at) begin
        upd = 1'b1;
        drive(newc);
        nxt  = newc;
        pend = 1'b1;
      end
      if (i == chg_at) drive(newc);
      tick();
      advance();
    end
    chk(hs_low == c[0], {tag, " R3 hsync width"}, hs_low, c[0]);
    chk(vs_low == c[4], {tag, " R3 vsync lines"}, vs_low, c[4]);
    chk(pix == c[2], {tag, " R4 active pixels per line"}, pix, c[2]);
    chk(lines == c[6], {tag, " R4 active lines per frame"}, lines, c[6]);
    chk(fs == 1'b1, {tag, " R2 frame period"}, int'(fs), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    drive(cfg_a);
    tick(); tick(); tick();
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_idle("R1 after reset");
    end
    // Input change with no update while idle.
    drive(cfg_b);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_idle("R7 idle input change");
    end
    drive(cfg_a);
    // First update: captured at E1, raster starts at E2.
    upd = 1'b1;
    tick();
    upd = 1'b0;
    chk_idle("R9 after E1");
    tick();
    chk(fs && hcnt == '0 && vcnt == '0, "R9 start after E2",
        int'(fs) * 10000 + int'(hcnt) * 100 + int'(vcnt), 10000);
    cur = cfg_a;
    ex = 0; ey = 0;
    run_frame("R2 shape A", -1, -1, cfg_a);
    run_frame("R7 inputs changed without update", -1, 10, cfg_b);
    run_frame("R8 update mid frame", 20, -1, cfg_b);
    chk(cur[0] == cfg_b[0] && cur[2] == cfg_b[2], "R8 model switched", cur[0], cfg_b[0]);
    run_frame("R8 shape B", -1, -1, cfg_b);
    run_frame("R3 shape B repeat", 30, -1, cfg_a);
    run_frame("R4 shape A again", -1, -1, cfg_a);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule